// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns a raw, asynchronous external interrupt pin into a clean, single-cycle request for the interrupt controller. The pin is first brought into the system clock domain by a flop chain. A digital agreement filter then treats any level that is not seen on consecutive clock samples as noise. Last, an edge detector picks the rising or the falling transition and produces the request. With the request it presents a fixed service vector of 0x003.

The filter exists to reject pulses shorter than one system clock period. It is bypassed whenever the chip runs from a low-frequency crystal, because there the clock is too slow to filter usefully. A separate option bit can also turn it off. The edge choice is a live control bit. Changing it is guarded, so that the change alone never looks like an edge. Masking, prioritising and vectoring of the request belong to the controller.

Top module: `ext_irq_conditioner`

## Requirements
- R1: After reset, and with no pin transition, `irq_o` stays low.
- R2: With `edge_sel_i` = 1 (rising), each low-to-high pin transition yields one request, and a high-to-low transition yields none.
- R3: With the filter active, a new level is accepted only after it has been sampled identical on two consecutive clock edges at the synchronizer output. A pin pulse that covers only one clock sample, or that falls between two clock edges, produces no request. A pulse covering two samples is accepted.
- R4: With `lowxtal_i` = 1 the filter is bypassed, so a pin pulse seen on a single clock sample produces a request.
- R5: With `filt_en_i` = 0 the filter is bypassed in the same way, whatever `lowxtal_i` is.
- R6: With `edge_sel_i` = 0 (falling), each high-to-low pin transition yields one request, and a low-to-high transition yields none.
- R7: `irq_o` is never high for two cycles in a row.
- R8: Changing `edge_sel_i` while the pin is steady produces no request.
- R9: `vec_o` presents 0x003 whenever `irq_o` is high.
- R10: Latency runs from a pin change applied between clock edges to the clock cycle in which `irq_o` is high. That cycle follows the 5th rising clock edge with the filter active, and the 3rd with the filter bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw external interrupt pin, asynchronous |
| edge_sel_i | input | 1 | Active edge: 1 rising, 0 falling |
| lowxtal_i | input | 1 | Low-frequency crystal mode; 1 bypasses the filter |
| filt_en_i | input | 1 | Filter option; 0 bypasses the filter |
| irq_o | output | 1 | One-cycle interrupt request |
| vec_o | output | VEC_W | Service vector of the request (0x003) |

## Verification
A filter register holding the wrong level has two visible effects. A genuine edge is lost, or a request appears without any pin activity. Either shows on `irq_o` within about five cycles of the stimulus, because every scenario watches a fixed window and checks both the pulse count and the cycle the pulse lands in. A stale history bit in the edge detector shows within one cycle of an `edge_sel_i` change, as a spurious pulse. A miscounted synchronizer or filter stage moves the pulse off its expected cycle.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;
   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_pol_e;

   localparam int unsigned EXT_VEC_W  = 12;
   localparam logic [11:0] EXT_IRQ_VEC = 12'h003;
endpackage

// File: rtl/eirq_sync.sv
`timescale 1ns/1ps
module eirq_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_LVL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("eirq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] stg_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= {STAGES{RST_LVL}};
      else         stg_q <= {stg_q[STAGES-2:0], d_i};
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/eirq_filter.sv
`timescale 1ns/1ps
module eirq_filter #(
   parameter int unsigned DEPTH   = 2,
   parameter logic        RST_LVL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   input  logic bypass_i,
   output logic q_o
);
   localparam int unsigned HW = (DEPTH > 1) ? DEPTH - 1 : 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("eirq_filter: DEPTH must be at least 2");
      end
   endgenerate

   logic [HW-1:0] hist_q;
   logic          agree;
   logic          filt_q;

   // History of the most recent DEPTH-1 samples, newest in bit 0.
   generate
      if (HW == 1) begin : g_hist_one
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) hist_q <= RST_LVL;
            else         hist_q <= d_i;
         end
      end else begin : g_hist_many
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) hist_q <= {HW{RST_LVL}};
            else         hist_q <= {hist_q[HW-2:0], d_i};
         end
      end
   endgenerate

   assign agree = (hist_q == {HW{d_i}});

   // In bypass the filtered level tracks the input so leaving bypass is seamless.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  filt_q <= RST_LVL;
      else if (bypass_i || agree)   filt_q <= d_i;
   end

   assign q_o = bypass_i ? d_i : filt_q;

   // R3: a change of the filtered level is backed by two equal samples
   assert_filt_two_samples_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(!bypass_i) && (filt_q != $past(filt_q)))
         |-> (($past(d_i) == filt_q) && ($past(d_i, 2) == filt_q)));
endmodule

// File: rtl/eirq_edge.sv
`timescale 1ns/1ps
module eirq_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic level_i,
   input  logic sel_i,
   output logic irq_o
);
   import ext_irq_pkg::*;

   edge_pol_e pol;
   logic      norm;
   logic      prev_q;
   logic      sel_q;
   logic      irq_q;

   assign pol  = edge_pol_e'(sel_i);
   // Normalised level: a rise of norm is always the active edge.
   assign norm = (pol == EDGE_RISE) ? level_i : ~level_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b1;
         sel_q  <= 1'b1;
         irq_q  <= 1'b0;
      end else begin
         prev_q <= norm;
         sel_q  <= sel_i;
         // A select change flips norm; the stale history must not count as an edge.
         irq_q  <= (sel_i == sel_q) && norm && !prev_q;
      end
   end

   assign irq_o = irq_q;

   // R7: request is a single-cycle pulse
   assert_single_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |=> !irq_o);

   // R8: a select change alone never raises a request
   assert_no_sel_glitch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i != $past(sel_i)) |=> !irq_o);

   // R2, R6: the level behind a request matches the chosen polarity
   assert_polarity_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> ($past(level_i) == $past(sel_i)));
endmodule

// File: rtl/ext_irq_conditioner.sv
`timescale 1ns/1ps
module ext_irq_conditioner #(
   parameter int unsigned        SYNC_STAGES = 2,
   parameter int unsigned        FILT_DEPTH  = 2,
   parameter logic               RST_LVL     = 1'b0,
   parameter int unsigned        VEC_W       = ext_irq_pkg::EXT_VEC_W,
   parameter logic [VEC_W-1:0]   VECTOR      = VEC_W'(ext_irq_pkg::EXT_IRQ_VEC)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             pin_i,
   input  logic             edge_sel_i,
   input  logic             lowxtal_i,
   input  logic             filt_en_i,
   output logic             irq_o,
   output logic [VEC_W-1:0] vec_o
);
   generate
      if (VEC_W < 2) begin : g_bad_vec
         $error("ext_irq_conditioner: VEC_W must hold the vector 0x003");
      end
   endgenerate

   logic pin_sync;
   logic level;
   logic bypass;

   assign bypass = lowxtal_i || !filt_en_i;

   eirq_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_LVL (RST_LVL)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pin_i),
      .q_o    (pin_sync)
   );

   eirq_filter #(
      .DEPTH   (FILT_DEPTH),
      .RST_LVL (RST_LVL)
   ) u_filter (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .d_i      (pin_sync),
      .bypass_i (bypass),
      .q_o      (level)
   );

   eirq_edge u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (level),
      .sel_i   (edge_sel_i),
      .irq_o   (irq_o)
   );

   assign vec_o = VECTOR;

   // R4, R5: in bypass a synchronised rise with rising select reaches irq_o next cycle
   assert_bypass_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bypass && edge_sel_i && $past(edge_sel_i) && pin_sync && !$past(pin_sync)
       && $past(bypass)) |=> irq_o);
endmodule

// File: tb/tb_ext_irq_conditioner.sv
`timescale 1ns/1ps
module tb_ext_irq_conditioner;
   localparam int LAT_FILT = 5;
   localparam int LAT_BYP  = 3;
   localparam int WIN      = 12;

   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        pin = 1'b0;
   logic        edge_sel = 1'b1;
   logic        lowxtal = 1'b0;
   logic        filt_en = 1'b1;
   logic        irq;
   logic [11:0] vec;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   ext_irq_conditioner dut (
      .clk_i      (clk),
      .rst_ni     (rst_ni),
      .pin_i      (pin),
      .edge_sel_i (edge_sel),
      .lowxtal_i  (lowxtal),
      .filt_en_i  (filt_en),
      .irq_o      (irq),
      .vec_o      (vec)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Watch WIN negedges; count high cycles, first index, vector at pulses.
   task automatic watch(output int hi, output int first, output int vec_bad);
      hi = 0; first = -1; vec_bad = 0;
      for (int k = 1; k <= WIN; k++) begin
         @(negedge clk);
         if (irq) begin
            hi++;
            if (first < 0) first = k;
            if (vec != 12'h003) vec_bad++;
         end
      end
   endtask

   task automatic t_reset();
      int hi;
      hi = 0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (irq) hi++;
      end
      rst_ni = 1'b1;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (irq) hi++;
      end
      check("R1", "irq cycles around reset", hi, 0);
      check("R9", "vector value", int'(vec), 3);
   endtask

   task automatic t_rise_filtered();
      int hi, first, vb;
      edge_sel = 1'b1;
      @(negedge clk); pin = 1'b1;
      watch(hi, first, vb);
      check("R2", "rising edge pulses", hi, 1);
      check("R10", "filtered latency", first, LAT_FILT);
      check("R9", "vector at request", vb, 0);
      check("R7", "pulse width cycles", hi, 1);
      @(negedge clk); pin = 1'b0;
      watch(hi, first, vb);
      check("R2", "falling edge ignored", hi, 0);
   endtask

   task automatic t_fall_and_select();
      int hi, first, vb;
      @(negedge clk); edge_sel = 1'b0;
      watch(hi, first, vb);
      check("R8", "select change to falling", hi, 0);
      @(negedge clk); pin = 1'b1;
      watch(hi, first, vb);
      check("R6", "rising ignored in falling mode", hi, 0);
      @(negedge clk); pin = 1'b0;
      watch(hi, first, vb);
      check("R6", "falling edge pulses", hi, 1);
      check("R10", "falling latency", first, LAT_FILT);
      @(negedge clk); edge_sel = 1'b1;
      watch(hi, first, vb);
      check("R8", "select change to rising", hi, 0);
   endtask

   task automatic t_glitch();
      int hi, first, vb;
      @(negedge clk); pin = 1'b1;
      @(negedge clk); pin = 1'b0;
      watch(hi, first, vb);
      check("R3", "one-sample pulse rejected", hi, 0);
      @(negedge clk); #0.5 pin = 1'b1; #1 pin = 1'b0;
      watch(hi, first, vb);
      check("R3", "sub-period pulse rejected", hi, 0);
      @(negedge clk); pin = 1'b1;
      @(negedge clk);
      @(negedge clk); pin = 1'b0;
      watch(hi, first, vb);
      check("R3", "two-sample pulse accepted", hi, 1);
      check("R3", "two-sample pulse latency", first, LAT_FILT - 2);
   endtask

   task automatic t_bypass(input bit use_lxt);
      int hi, first, vb;
      string rq;
      rq = use_lxt ? "R4" : "R5";
      @(negedge clk);
      if (use_lxt) lowxtal = 1'b1; else filt_en = 1'b0;
      watch(hi, first, vb);
      check(rq, "entering bypass quiet", hi, 0);
      @(negedge clk); pin = 1'b1;
      @(negedge clk); pin = 1'b0;
      watch(hi, first, vb);
      check(rq, "one-sample pulse passes", hi, 1);
      @(negedge clk); pin = 1'b1;
      watch(hi, first, vb);
      check("R10", "bypass latency", first, LAT_BYP);
      @(negedge clk); pin = 1'b0;
      watch(hi, first, vb);
      check(rq, "falling ignored in bypass", hi, 0);
      @(negedge clk); lowxtal = 1'b0; filt_en = 1'b1;
      watch(hi, first, vb);
      check(rq, "leaving bypass quiet", hi, 0);
   endtask

   initial begin
      t_reset();
      t_rise_filtered();
      t_fall_and_select();
      t_glitch();
      t_bypass(1'b1);
      t_bypass(1'b0);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5 * 20000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule